// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block turns one block-transfer instruction into a run of simple micro-ops. The instruction supplies a 16-bit mask of the registers to move, a base register, and five control bits: ascending or descending addressing, pre- or post-indexing, base update, load or store, and a user-bank flag. The block accepts the instruction over a valid/ready handshake and then issues one micro-op per accepted cycle on a second valid/ready handshake.

The first micro-op copies the base into a scratch register. Each memory micro-op then addresses relative to that scratch register, so a load that overwrites the base register does not disturb the later addresses. An optional final micro-op moves the base past the transferred block. Register indices on the output are 6 bits wide. Values 0..15 are the normal registers, 16..31 are the user-bank views of registers 0..15 (index + 16), and 32 is the scratch register.

Opcode encoding on `uopOpcode`: 0 add-immediate, 1 subtract-immediate, 2 load, 3 exception-return load (a load that also restores the status register from its saved copy), 4 store.

Top module: `ldstm_uop_seq`

## Requirements
- R1: After an instruction is accepted, the first micro-op is opcode 0 with register 32, the instruction's base register as base, and immediate 0.
- R2: One memory micro-op follows for each set mask bit, in ascending register order, each with base 32. Loads use opcode 2 and stores use opcode 4 unless R6 applies.
- R3: In ascending mode the memory offsets are 0, 4, 8, and so on. Pre-indexing adds 4 to every offset.
- R4: In descending mode the memory offsets are 4N-4, 4N-8, and so on down to 0, where N is the number of set mask bits. Pre-indexing adds 4 to every offset.
- R5: For a load with the user-bank flag set and mask bit 15 clear, every register index is reported as index + 16.
- R6: For a load with the user-bank flag set and mask bit 15 set, register 15 is issued with opcode 3 and index 15. No index in that instruction is remapped.
- R7: For a store with the user-bank flag set, every index, 15 included, is reported as index + 16, and opcode 3 never appears.
- R8: With base update requested, a final micro-op on the base register (as both register and base) adds 4N in ascending mode (opcode 0) or subtracts 4N in descending mode (opcode 1).
- R9: `uopLast` is high only on the final micro-op of an instruction. `uopValid` is low in the cycle after that micro-op is taken.
- R10: An empty mask issues only the copy micro-op, followed by the update micro-op with immediate 0 if one is requested. The last flag marks whichever of these is final.
- R11: `inReady` is high only while no sequence is in progress. Instruction inputs offered during a sequence are ignored. While `uopValid` is high and `uopReady` is low, every micro-op output holds steady.
- R12: Reset, even in the middle of a sequence, clears `uopValid` and raises `inReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Sequencer idle, instruction can be taken |
| regMask | input | 16 | Registers to transfer |
| baseReg | input | 4 | Base register index |
| upMode | input | 1 | 1 ascending, 0 descending addresses |
| preIndex | input | 1 | Offset by one word before the first transfer |
| writeBack | input | 1 | Append a base-update micro-op |
| isLoad | input | 1 | 1 load, 0 store |
| userBank | input | 1 | User-bank / exception-return qualifier |
| uopValid | output | 1 | Micro-op present |
| uopReady | input | 1 | Consumer takes the micro-op |
| uopOpcode | output | 3 | Micro-op kind (encoding above) |
| uopReg | output | 6 | Destination or source register index |
| uopBase | output | 6 | Base register index |
| uopImm | output | 8 | Immediate or offset |
| uopLast | output | 1 | Final micro-op of the instruction |

## Verification
Two functions can land on the same micro-op: the exception-return load of register 15 is always the last memory transfer, so it may also carry the final flag, or it may be followed by the base update. Instructions with register 15 in a user-bank load are run both with and without base update, and with a ready pattern that stalls on that micro-op. The bench checks that opcode 3 appears exactly once at the expected position and that the last flag moves to the update micro-op when one follows. It also checks that every field holds across the stall.

// File: rtl/lsm_pkg.sv
`timescale 1ns/1ps
package lsm_pkg;
  localparam int NREG  = 16;
  localparam int RIDX  = $clog2(NREG);
  localparam int IDXW  = RIDX + 2;
  localparam int IMMW  = 8;
  localparam int CNTW  = $clog2(NREG + 1);
  localparam int WORD  = 4;
  localparam logic [IDXW-1:0] TEMP_IDX = IDXW'(2 * NREG);

  typedef enum logic [2:0] {
    OP_ADDI  = 3'd0,
    OP_SUBI  = 3'd1,
    OP_LOAD  = 3'd2,
    OP_LDRET = 3'd3,
    OP_STORE = 3'd4
  } uop_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COPY = 2'd1,
    PH_XFER = 2'd2,
    PH_WB   = 2'd3
  } phase_e;

  typedef struct packed {
    logic capture;
    logic advance;
  } strobe_t;
endpackage

// File: rtl/lsm_ctrl.sv
`timescale 1ns/1ps
module lsm_ctrl
  import lsm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    uopReady,
  input  logic    remEmpty,
  input  logic    remSingle,
  input  logic    wbFlag,
  output phase_e  phase,
  output strobe_t strobes,
  output logic    inReady,
  output logic    uopValid,
  output logic    uopLast
);
  phase_e phaseNext;
  logic   fire;

  assign fire     = uopValid && uopReady;
  assign inReady  = (phase == PH_IDLE);
  assign uopValid = (phase != PH_IDLE);

  always_comb begin
    phaseNext       = phase;
    strobes.capture = 1'b0;
    strobes.advance = 1'b0;
    uopLast         = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        strobes.capture = inValid;
        if (inValid) phaseNext = PH_COPY;
      end
      PH_COPY: begin
        uopLast = remEmpty && !wbFlag;
        if (fire) phaseNext = !remEmpty ? PH_XFER : (wbFlag ? PH_WB : PH_IDLE);
      end
      PH_XFER: begin
        uopLast         = remSingle && !wbFlag;
        strobes.advance = fire;
        if (fire && remSingle) phaseNext = wbFlag ? PH_WB : PH_IDLE;
      end
      PH_WB: begin
        uopLast = 1'b1;
        if (fire) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // R11: a stalled micro-op keeps its flag
  a_r11_hold_last: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopReady |=> uopValid && $stable(uopLast));
  // R9: nothing valid right after the final micro-op is taken
  a_r9_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    fire && uopLast |=> !uopValid);
endmodule

// File: rtl/lsm_dpath.sv
`timescale 1ns/1ps
module lsm_dpath
  import lsm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobes,
  input  phase_e          phase,
  input  logic [NREG-1:0] regMask,
  input  logic [RIDX-1:0] baseReg,
  input  logic            upMode,
  input  logic            preIndex,
  input  logic            writeBack,
  input  logic            isLoad,
  input  logic            userBank,
  output logic            remEmpty,
  output logic            remSingle,
  output logic            wbFlag,
  output uop_e            uopOp,
  output logic [IDXW-1:0] uopReg,
  output logic [IDXW-1:0] uopBase,
  output logic [IMMW-1:0] uopImm
);
  logic [NREG-1:0] remMask;
  logic [RIDX-1:0] baseQ;
  logic [IMMW-1:0] offQ;
  logic [CNTW-1:0] cntQ;
  logic            upQ, ldQ, remapQ, retQ;
  logic [RIDX-1:0] curIdx;
  logic [CNTW-1:0] cntIn;
  logic [IMMW-1:0] startOff;
  logic [IMMW-1:0] blockBytes;

  function automatic logic [RIDX-1:0] lowestSet(input logic [NREG-1:0] m);
    lowestSet = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (m[i]) lowestSet = RIDX'(i);
  endfunction

  assign curIdx     = lowestSet(remMask);
  assign remEmpty   = (remMask == '0);
  assign remSingle  = $onehot(remMask);
  assign cntIn      = CNTW'($countones(regMask));
  assign blockBytes = IMMW'(cntQ) * IMMW'(WORD);

  always_comb begin
    startOff = upMode ? '0 : (IMMW'(cntIn) * IMMW'(WORD) - IMMW'(WORD));
    if (preIndex) startOff = startOff + IMMW'(WORD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remMask <= '0;
      baseQ   <= '0;
      offQ    <= '0;
      cntQ    <= '0;
      upQ     <= 1'b0;
      wbFlag  <= 1'b0;
      ldQ     <= 1'b0;
      remapQ  <= 1'b0;
      retQ    <= 1'b0;
    end else if (strobes.capture) begin
      remMask <= regMask;
      baseQ   <= baseReg;
      offQ    <= startOff;
      cntQ    <= cntIn;
      upQ     <= upMode;
      wbFlag  <= writeBack;
      ldQ     <= isLoad;
      retQ    <= userBank && isLoad && regMask[NREG-1];
      remapQ  <= userBank && !(isLoad && regMask[NREG-1]);
    end else if (strobes.advance) begin
      remMask[curIdx] <= 1'b0;
      offQ <= upQ ? offQ + IMMW'(WORD) : offQ - IMMW'(WORD);
    end
  end

  always_comb begin
    uopOp   = OP_ADDI;
    uopReg  = '0;
    uopBase = '0;
    uopImm  = '0;
    unique case (phase)
      PH_COPY: begin
        uopReg  = TEMP_IDX;
        uopBase = IDXW'(baseQ);
      end
      PH_XFER: begin
        if (!ldQ)                                    uopOp = OP_STORE;
        else if (retQ && curIdx == RIDX'(NREG - 1))  uopOp = OP_LDRET;
        else                                         uopOp = OP_LOAD;
        uopReg  = remapQ ? IDXW'(curIdx) + IDXW'(NREG) : IDXW'(curIdx);
        uopBase = TEMP_IDX;
        uopImm  = offQ;
      end
      PH_WB: begin
        uopOp   = upQ ? OP_ADDI : OP_SUBI;
        uopReg  = IDXW'(baseQ);
        uopBase = IDXW'(baseQ);
        uopImm  = blockBytes;
      end
      default: ;
    endcase
  end

  // R2: each transfer retires exactly one register and adds none
  a_r2_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> $countones(remMask) + 1 == $countones($past(remMask)));
  a_r2_subset: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> (remMask & ~$past(remMask)) == '0);
endmodule

// File: rtl/ldstm_uop_seq.sv
`timescale 1ns/1ps
module ldstm_uop_seq
  import lsm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [NREG-1:0] regMask,
  input  logic [RIDX-1:0] baseReg,
  input  logic            upMode,
  input  logic            preIndex,
  input  logic            writeBack,
  input  logic            isLoad,
  input  logic            userBank,
  output logic            uopValid,
  input  logic            uopReady,
  output logic [2:0]      uopOpcode,
  output logic [IDXW-1:0] uopReg,
  output logic [IDXW-1:0] uopBase,
  output logic [IMMW-1:0] uopImm,
  output logic            uopLast
);
  phase_e  phase;
  strobe_t strobes;
  logic    remEmpty, remSingle, wbFlag;
  uop_e    uopOp;

  lsm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .uopReady(uopReady),
    .remEmpty(remEmpty), .remSingle(remSingle), .wbFlag(wbFlag),
    .phase(phase), .strobes(strobes), .inReady(inReady),
    .uopValid(uopValid), .uopLast(uopLast)
  );

  lsm_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .phase(phase),
    .regMask(regMask), .baseReg(baseReg), .upMode(upMode),
    .preIndex(preIndex), .writeBack(writeBack), .isLoad(isLoad),
    .userBank(userBank), .remEmpty(remEmpty), .remSingle(remSingle),
    .wbFlag(wbFlag), .uopOp(uopOp), .uopReg(uopReg),
    .uopBase(uopBase), .uopImm(uopImm)
  );

  assign uopOpcode = uopOp;

  // R1: the micro-op after an accepted instruction is the scratch copy
  a_r1_copy_first: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> uopValid && uopOpcode == 3'd0 && uopReg == TEMP_IDX && uopImm == '0);
  // R8: a base update is always the final micro-op
  a_r8_wb_is_last: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && uopOpcode <= 3'd1 && uopReg != TEMP_IDX |-> uopLast);
  // R6: the exception-return load only ever targets register 15
  a_r6_ret_pc_only: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && uopOpcode == 3'd3 |-> uopReg == IDXW'(NREG - 1) && uopBase == TEMP_IDX);
  // R11: no instruction is taken while a micro-op is pending
  a_r11_busy: assert property (@(posedge clk) disable iff (!rstN)
    uopValid |-> !inReady);
  a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopReady |=> $stable(uopOpcode) && $stable(uopReg) && $stable(uopImm) && $stable(uopBase));
endmodule

// File: tb/sim_ldstm_uop_seq.sv
`timescale 1ns/1ps
module sim_ldstm_uop_seq;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [15:0] regMask = '0;
  logic [3:0] baseReg = '0;
  logic upMode = 0, preIndex = 0, writeBack = 0, isLoad = 0, userBank = 0;
  logic uopValid, uopReady = 1'b0, uopLast;
  logic [2:0] uopOpcode;
  logic [5:0] uopReg, uopBase;
  logic [7:0] uopImm;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  ldstm_uop_seq u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .regMask(regMask), .baseReg(baseReg), .upMode(upMode), .preIndex(preIndex),
    .writeBack(writeBack), .isLoad(isLoad), .userBank(userBank),
    .uopValid(uopValid), .uopReady(uopReady), .uopOpcode(uopOpcode),
    .uopReg(uopReg), .uopBase(uopBase), .uopImm(uopImm), .uopLast(uopLast)
  );

  // {stall pattern, mask, base, {up, pre, wb, load, user}}
  localparam logic [32:0] VEC [12] = '{
    {8'hFF, 16'h0001, 4'd2,  5'b10010},
    {8'hFF, 16'h00F0, 4'd13, 5'b10110},
    {8'hA5, 16'h8421, 4'd1,  5'b01100},
    {8'hFF, 16'hFFFF, 4'd0,  5'b00010},
    {8'h6D, 16'h1234, 4'd5,  5'b11100},
    {8'hFF, 16'h0000, 4'd3,  5'b00100},
    {8'hFF, 16'h0000, 4'd4,  5'b10000},
    {8'hB3, 16'h8003, 4'd6,  5'b10011},
    {8'hFF, 16'h800C, 4'd7,  5'b10001},
    {8'h5F, 16'h00C1, 4'd9,  5'b00111},
    {8'hFF, 16'h8000, 4'd10, 5'b01011},
    {8'h77, 16'hC000, 4'd11, 5'b10111}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runSeq(input logic [32:0] v, input bit poke);
    logic [7:0] stall = v[32:25];
    logic [15:0] m = v[24:9];
    logic [3:0] b = v[8:5];
    bit up = v[4], pre = v[3], wb = v[2], ld = v[1], usr = v[0];
    int eOp[18], eReg[18], eBase[18], eImm[18];
    string tg[18], immTag[18];
    int n = $countones(m), off, total, k, cyc;
    bit held = 0;
    int hOp, hReg, hImm, hLast;
    off = up ? 0 : 4 * n - 4;
    if (pre) off += 4;
    eOp[0] = 0; eReg[0] = 32; eBase[0] = b; eImm[0] = 0;
    tg[0] = (n == 0) ? "R10" : "R1"; immTag[0] = tg[0];
    total = 1;
    for (int r = 0; r < 16; r++) if (m[r]) begin
      eOp[total]   = ld ? ((usr && r == 15) ? 3 : 2) : 4;
      eReg[total]  = (usr && !(ld && m[15])) ? r + 16 : r;
      eBase[total] = 32;
      eImm[total]  = off & 255;
      tg[total]    = (eOp[total] == 3) ? "R6" : (usr ? (ld ? "R5" : "R7") : "R2");
      immTag[total] = up ? "R3" : "R4";
      off = up ? off + 4 : off - 4;
      total++;
    end
    if (wb) begin
      eOp[total] = up ? 0 : 1; eReg[total] = b; eBase[total] = b;
      eImm[total] = 4 * n; tg[total] = (n == 0) ? "R10" : "R8"; immTag[total] = tg[total];
      total++;
    end
    @(negedge clk);
    regMask = m; baseReg = b; upMode = up; preIndex = pre;
    writeBack = wb; isLoad = ld; userBank = usr; inValid = 1; uopReady = 0;
    check(inReady == 1, "R11", int'(inReady), 1);
    @(posedge clk);
    k = 0; cyc = 0;
    while (k < total && cyc < 100) begin
      @(negedge clk);
      inValid = poke && (k < total - 1);
      if (poke) begin regMask = 16'hFFFF; baseReg = 4'd15; upMode = ~up; writeBack = 1; end
      check(uopValid == 1, "R11", int'(uopValid), 1);
      check(inReady == 0, "R11", int'(inReady), 0);
      if (held) begin
        check(uopOpcode == hOp && uopReg == hReg && uopImm == hImm && uopLast == hLast,
              "R11", int'(uopReg), hReg);
        held = 0;
      end
      uopReady = stall[cyc % 8];
      cyc++;
      if (uopValid && uopReady) begin
        check(uopOpcode == eOp[k] && uopReg == eReg[k] && uopBase == eBase[k], tg[k],
              int'(uopOpcode) * 100 + int'(uopReg), eOp[k] * 100 + eReg[k]);
        check(uopImm == eImm[k], immTag[k], int'(uopImm), eImm[k]);
        check(uopLast == (k == total - 1), "R9", int'(uopLast), int'(k == total - 1));
        k++;
      end else if (uopValid) begin
        held = 1; hOp = uopOpcode; hReg = uopReg; hImm = uopImm; hLast = uopLast;
      end
    end
    check(cyc < 100, "R11", cyc, 100);
    @(negedge clk);
    inValid = 0; uopReady = 0;
    check(uopValid == 0 && inReady == 1, "R9", int'(uopValid), 0);
  endtask

  initial begin
    #1;
    check(uopValid == 0, "R12", int'(uopValid), 0);
    check(inReady == 1, "R12", int'(inReady), 1);
    repeat (3) @(negedge clk);
    rstN = 1;
    foreach (VEC[i]) runSeq(VEC[i], 1'b0);
    // ignored instruction inputs while busy, with exception-return plus update
    runSeq(VEC[11], 1'b1);
    runSeq(VEC[3], 1'b1);
    // reset in the middle of a sequence
    @(negedge clk);
    regMask = 16'h00FF; isLoad = 1; inValid = 1; uopReady = 0;
    @(negedge clk);
    inValid = 0;
    @(negedge clk);
    check(uopValid == 1, "R12", int'(uopValid), 1);
    rstN = 0;
    #1;
    check(uopValid == 0, "R12", int'(uopValid), 0);
    check(inReady == 1, "R12", int'(inReady), 1);
    @(negedge clk);
    rstN = 1;
    runSeq(VEC[1], 1'b0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL R11: watchdog expired, actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule